// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the 16-bit instruction address of a small processor core and picks the next one on every enabled clock edge. The fetch stage feeds it the instruction that was fetched at the current address. The register-read stage feeds it the two operand values that the conditional branch compares. The block decodes the opcode and chooses one of three next addresses: the plain sequential step, a relative branch target, or an absolute jump target. It then loads that choice into the counter register.

All instructions are 16 bits wide and aligned to even addresses, so the sequential step is +2. A conditional branch jumps when its two operands differ. Its 4-bit signed offset counts whole instructions from the address after the branch. An absolute jump keeps the upper address bits of the sequential address and replaces everything below them with a 12-bit field followed by a zero. All address arithmetic wraps modulo 2^16.

Top module: `pc_next_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pc` becomes 0x0000 after that edge, whatever the value of `en`.
- R2: With `en` high and an opcode (bits 15:12 of `instr`) other than 0x9 or 0xB, `pc` becomes `pc + 2` after the edge.
- R3: With `en` low and `rst` low, `pc` keeps its value across the edge, whatever the instruction and operands.
- R4: With `en` high, opcode 0x9, and `op_a != op_b`, `pc` becomes `pc + 2 + 2*sext(instr[3:0])`. The offset is a two's-complement word count in the range -8 to +7.
- R5: With `en` high, opcode 0x9, and `op_a == op_b`, `pc` becomes `pc + 2`.
- R6: With `en` high and opcode 0xB, `pc` becomes `{(pc+2)[15:13], instr[11:0], 1'b0}`.
- R7: Sequential, branch and jump arithmetic all wrap modulo 2^16. For example, 0xFFFE steps to 0x0000, and a branch with offset -8 taken from 0x0000 lands on 0xFFF2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; low holds the counter |
| instr | input | 16 | Instruction fetched at the current `pc` |
| op_a | input | 16 | First branch compare operand |
| op_b | input | 16 | Second branch compare operand |
| pc | output | 16 | Registered program counter |

## Verification
The counter is the only state, so any fault in decode, compare or target arithmetic appears on `pc` right after the edge that loaded the wrong value. Every later address is built on that value, so the error carries forward and does not recover without a reset. The bench compares `pc` after every edge with a model address. That catches a wrong sign extension, a missing word shift, a swapped compare sense or a wrong jump field one cycle after the faulty instruction. A stall that fails to hold shows up on the same edge.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    FLOW_SEQ = 2'd0,
    FLOW_BNE = 2'd1,
    FLOW_JMP = 2'd2
  } flow_t;
endpackage

// File: rtl/pc_flow_decode.sv
module pc_flow_decode
  import pc_pkg::*;
#(
  parameter int          OPC_W   = 4,
  parameter int          DATA_W  = 16,
  parameter logic [3:0]  OPC_BNE = 4'h9,
  parameter logic [3:0]  OPC_JMP = 4'hB
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output flow_t             flow
);
  logic differ;

  assign differ = (op_a != op_b);

  always_comb begin
    flow = FLOW_SEQ;
    if (opcode == OPC_W'(OPC_JMP)) begin
      flow = FLOW_JMP;
    end else if (opcode == OPC_W'(OPC_BNE) && differ) begin
      flow = FLOW_BNE;
    end
  end
endmodule

// File: rtl/pc_target_gen.sv
module pc_target_gen
  import pc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BOFF_W = 4,
  parameter int JF_W   = 12
) (
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [BOFF_W-1:0] br_ofs,
  input  logic [JF_W-1:0]   jmp_field,
  input  flow_t             flow,
  output logic [ADDR_W-1:0] next_pc
);
  localparam int HI_W  = ADDR_W - JF_W - 1;
  localparam int EXT_W = ADDR_W - BOFF_W - 1;

  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] br_step;
  logic [ADDR_W-1:0] br_pc;
  logic [ADDR_W-1:0] jmp_pc;

  assign seq_pc  = cur_pc + ADDR_W'(2);
  assign br_step = {{EXT_W{br_ofs[BOFF_W-1]}}, br_ofs, 1'b0};
  assign br_pc   = seq_pc + br_step;

  generate
    if (HI_W > 0) begin : g_keep_hi
      assign jmp_pc = {seq_pc[ADDR_W-1 -: HI_W], jmp_field, 1'b0};
    end else begin : g_no_hi
      assign jmp_pc = ADDR_W'({jmp_field, 1'b0});
    end
  endgenerate

  always_comb begin
    unique case (flow)
      FLOW_BNE: next_pc = br_pc;
      FLOW_JMP: next_pc = jmp_pc;
      default:  next_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/pc_state_reg.sv
module pc_state_reg #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RESET_PC;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pc_pkg::*;
#(
  parameter int         ADDR_W  = 16,
  parameter int         INSTR_W = 16,
  parameter int         OPC_W   = 4,
  parameter int         BOFF_W  = 4,
  parameter int         JF_W    = 12,
  parameter logic [3:0] OPC_BNE = 4'h9,
  parameter logic [3:0] OPC_JMP = 4'hB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  op_a,
  input  logic [ADDR_W-1:0]  op_b,
  output logic [ADDR_W-1:0]  pc
);
  flow_t             flow;
  logic [ADDR_W-1:0] next_pc;

  pc_flow_decode #(
    .OPC_W(OPC_W), .DATA_W(ADDR_W), .OPC_BNE(OPC_BNE), .OPC_JMP(OPC_JMP)
  ) u_decode (
    .opcode (instr[INSTR_W-1 -: OPC_W]),
    .op_a   (op_a),
    .op_b   (op_b),
    .flow   (flow)
  );

  pc_target_gen #(
    .ADDR_W(ADDR_W), .BOFF_W(BOFF_W), .JF_W(JF_W)
  ) u_target (
    .cur_pc    (pc),
    .br_ofs    (instr[BOFF_W-1:0]),
    .jmp_field (instr[JF_W-1:0]),
    .flow      (flow),
    .next_pc   (next_pc)
  );

  pc_state_reg #(
    .ADDR_W(ADDR_W), .RESET_PC('0)
  ) u_reg (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d   (next_pc),
    .q   (pc)
  );
endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk #(
  parameter int         ADDR_W  = 16,
  parameter int         INSTR_W = 16,
  parameter int         OPC_W   = 4,
  parameter int         BOFF_W  = 4,
  parameter int         JF_W    = 12,
  parameter logic [3:0] OPC_BNE = 4'h9,
  parameter logic [3:0] OPC_JMP = 4'hB
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic [INSTR_W-1:0] instr,
  input logic [ADDR_W-1:0]  op_a,
  input logic [ADDR_W-1:0]  op_b,
  input logic [ADDR_W-1:0]  pc
);
  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] ofs_ext;
  logic [ADDR_W-1:0] seq_nxt;
  logic              is_bne;
  logic              is_jmp;
  logic              rst_q;

  assign opc     = instr[INSTR_W-1 -: OPC_W];
  assign ofs_ext = ADDR_W'($signed(instr[BOFF_W-1:0]));
  assign seq_nxt = pc + ADDR_W'(2);
  assign is_bne  = (opc == OPC_W'(OPC_BNE));
  assign is_jmp  = (opc == OPC_W'(OPC_JMP));

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      p_reset_zero_r1: assert (pc == '0) else $error("pc not cleared by reset");
    end
  end

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !is_bne && !is_jmp) |=> pc == $past(seq_nxt));

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> $stable(pc));

  p_bne_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (en && is_bne && op_a != op_b) |=> pc == $past(seq_nxt) + ($past(ofs_ext) << 1));

  p_bne_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (en && is_bne && op_a == op_b) |=> pc == $past(seq_nxt));

  p_jmp_target_r6: assert property (@(posedge clk) disable iff (rst)
    (en && is_jmp) |=> pc == {$past(seq_nxt[ADDR_W-1:JF_W+1]), $past(instr[JF_W-1:0]), 1'b0});
endmodule

bind pc_next_unit pc_next_unit_chk #(
  .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .OPC_W(OPC_W), .BOFF_W(BOFF_W),
  .JF_W(JF_W), .OPC_BNE(OPC_BNE), .OPC_JMP(OPC_JMP)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .instr(instr),
  .op_a(op_a), .op_b(op_b), .pc(pc)
);

// File: tb/test_pc_next_unit.sv
module test_pc_next_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic [15:0] instr;
  logic [15:0] op_a;
  logic [15:0] op_b;
  logic [15:0] pc;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_pc;
  bit done = 0;

  always #5 clk = ~clk;

  pc_next_unit i_pc_next_unit (
    .clk(clk), .rst(rst), .en(en), .instr(instr),
    .op_a(op_a), .op_b(op_b), .pc(pc)
  );

  function automatic logic [15:0] model_next(input logic [15:0] cur,
                                             input logic [15:0] ins,
                                             input logic [15:0] a,
                                             input logic [15:0] b);
    logic [15:0] nxt;
    int signed   words;
    nxt = cur + 16'd2;
    if (ins[15:12] == 4'hB) begin
      return {nxt[15:13], ins[11:0], 1'b0};
    end
    if (ins[15:12] == 4'h9 && a != b) begin
      words = (ins[3] ? int'(ins[3:0]) - 16 : int'(ins[3:0]));
      return nxt + 16'(words * 2);
    end
    return nxt;
  endfunction

  task automatic check(input string tag, input logic [15:0] want);
    checks++;
    if (pc !== want) begin
      errors++;
      $display("FAIL %s pc=%h expected=%h", tag, pc, want);
    end
  endtask

  // Drive on the falling edge, let one rising edge pass, check on the next falling edge.
  task automatic step(input string tag, input logic r, input logic e,
                      input logic [15:0] ins, input logic [15:0] a, input logic [15:0] b);
    rst = r; en = e; instr = ins; op_a = a; op_b = b;
    if (r) exp_pc = 16'h0000;
    else if (e) exp_pc = model_next(exp_pc, ins, a, b);
    @(posedge clk);
    @(negedge clk);
    check(tag, exp_pc);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int unsigned sel;
    void'($urandom(32'd1234));
    exp_pc = 16'h0;
    rst = 1'b1; en = 1'b0; instr = '0; op_a = '0; op_b = '0;
    @(negedge clk);
    step("R1 reset with en low", 1'b1, 1'b0, 16'h1234, 16'h0, 16'h0);
    step("R2 sequential", 1'b0, 1'b1, 16'h0123, 16'h0, 16'h0);
    step("R2 sequential", 1'b0, 1'b1, 16'h4FFF, 16'h0, 16'h0);
    step("R3 stall holds", 1'b0, 1'b0, 16'hB555, 16'h1, 16'h2);
    step("R3 stall holds on branch", 1'b0, 1'b0, 16'h9007, 16'h1, 16'h2);
    step("R4 forward branch +7", 1'b0, 1'b1, 16'h9007, 16'h5, 16'h6);
    step("R5 equal falls through", 1'b0, 1'b1, 16'h9008, 16'hAAAA, 16'hAAAA);
    step("R4 backward branch -1", 1'b0, 1'b1, 16'h900F, 16'h1, 16'h0);
    step("R1 reset mid-run", 1'b1, 1'b1, 16'h0000, 16'h0, 16'h0);
    step("R7 offset -8 wraps below zero", 1'b0, 1'b1, 16'h9008, 16'h3, 16'h4);
    step("R6 jump near top of memory", 1'b0, 1'b1, 16'hBFFF, 16'h0, 16'h0);
    check("R6 jump lands on 0xFFFE", 16'hFFFE);
    step("R7 sequential wrap", 1'b0, 1'b1, 16'h0000, 16'h0, 16'h0);
    check("R7 wrap gives 0x0000", 16'h0000);
    step("R6 jump from low page", 1'b0, 1'b1, 16'hB800, 16'h0, 16'h0);
    check("R6 jump target 0x1000", 16'h1000);

    for (int i = 0; i < 400; i++) begin
      sel = $urandom_range(0, 9);
      v = 16'($urandom);
      case (sel)
        0, 1, 2: v[15:12] = 4'h9;
        3, 4:    v[15:12] = 4'hB;
        default: if (v[15:12] == 4'h9 || v[15:12] == 4'hB) v[15:12] = 4'h2;
      endcase
      op_a = 16'($urandom);
      op_b = ($urandom_range(0, 3) == 0) ? op_a : 16'($urandom);
      if (v[15:12] == 4'h9)
        step(op_a == op_b ? "R5 random equal" : "R4 random branch",
             ($urandom_range(0, 49) == 0), ($urandom_range(0, 4) != 0), v, op_a, op_b);
      else if (v[15:12] == 4'hB)
        step("R6 random jump", ($urandom_range(0, 49) == 0), ($urandom_range(0, 4) != 0), v, op_a, op_b);
      else
        step("R2 R3 random sequential", ($urandom_range(0, 49) == 0), ($urandom_range(0, 4) != 0), v, op_a, op_b);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule